// File: doc/BRIEF.md
# Dual-Channel DMA Stall Watchdog

This block watches two DMA data paths and flags each one that sits stalled for too long. The transmit path times how long it waits for incoming data. The receive path times how long it waits for a read from memory to return. Each path has its own programmable prescaler, an 8-bit timeout threshold counted in prescaler ticks, an enable bit and a sticky interrupt flag. A clear input removes the flag.

Each prescaler counts clock cycles while its channel is enabled and stalled. It wraps once its count reaches 8000 shifted right by the channel's 3-bit shift amount, so the tick period can be set over a wide range from a single base constant. Every wrap adds one to a tick counter. The channel's interrupt flag sets once the tick count goes above the threshold. A data-transferred strobe, the end of the stall, or a low enable zeroes both counters.

All pins are plain control and status levels or strobes. No data moves through the block, so it has no valid/ready interface and no back-pressure rules. The configuration word is expected to come from a register owned elsewhere. Its usual power-up value is 0x0081_0810: both channels enabled, shift 0, threshold 16.

Top module: `dma_stall_watchdog`

## Requirements
- R1: While a channel is active (enable high, stall high, no transfer strobe), its prescale count rises by one each clock. On the clock after the count is at or above L = 8000 >> shift, the count returns to zero and one tick is produced. The tick period is therefore L+1 clocks, for every shift value 0 to 7.
- R2: Each tick adds one to the channel's tick count, which saturates at its top value. With threshold T, a continuous stall sets the interrupt on clock edge (T+1)*(L+1)+1, counting the first edge that sees the stall as edge 1. The interrupt is low on every earlier edge.
- R3: While a channel's enable is low, its interrupt never sets and its counters stay at zero. When enable rises during a stall, timing starts afresh from zero.
- R4: Field positions in cfg_word: transmit threshold [7:0], transmit shift [10:8], transmit enable [11]; receive threshold [19:12], receive shift [22:20], receive enable [23]. Bits [31:24] have no effect.
- R5: A transfer strobe, or the stall input going low, for a single cycle clears both counters of that channel. Timing then restarts from zero.
- R6: The interrupt stays set until the matching clear input is high at a clock edge. Clear wins over a set in the same cycle. After reset both interrupts are low.
- R7: With threshold 0, the interrupt sets one edge after the first prescaler wrap of a stall, which is edge L+2.
- R8: A configuration change takes effect from the next clock edge and does not reset counters already running.
- R9: The two channels are independent. Stall, transfer, clear and configuration of one channel never change the other channel's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word, field layout in R4 |
| tx_stall | input | 1 | Transmit path is waiting for incoming data |
| tx_xfer | input | 1 | Transmit path moved a data item this cycle |
| tx_irq_clr | input | 1 | Clears the transmit interrupt |
| rx_stall | input | 1 | Receive path is waiting for a memory read |
| rx_xfer | input | 1 | Receive path moved a data item this cycle |
| rx_irq_clr | input | 1 | Clears the receive interrupt |
| tx_hung_irq | output | 1 | Sticky transmit stall interrupt |
| rx_hung_irq | output | 1 | Sticky receive stall interrupt |

## Verification
The hardest case to reach from the ports is the exact prescaler wrap at shift 0, where one tick takes 8001 clocks and the tick count cannot be seen directly. The bench sets the threshold to 0 so that the interrupt edge exposes the wrap, then counts edges for each of the eight shift values. The clear-versus-set collision is another case that needs deliberate stimulus: the bench holds the stall past the threshold so the set condition stays true, keeps clear high over several edges, and then watches the flag return on the first edge after clear drops.

// File: rtl/stall_wd_pkg.sv
package stall_wd_pkg;

  localparam int THR_W     = 8;
  localparam int SHIFT_W   = 3;
  localparam int PS_W      = 13;
  localparam int PS_BASE   = 8000;
  localparam int CH_STRIDE = THR_W + SHIFT_W + 1;
  localparam int N_CH      = 2;

  localparam logic [31:0] CFG_POWERUP = 32'h0081_0810;

  typedef struct packed {
    logic               en;
    logic [SHIFT_W-1:0] shift;
    logic [THR_W-1:0]   thr;
  } chan_cfg_t;

  function automatic chan_cfg_t pick_cfg(input logic [31:0] word, input int ch);
    chan_cfg_t c;
    c.thr   = word[ch*CH_STRIDE +: THR_W];
    c.shift = word[ch*CH_STRIDE + THR_W +: SHIFT_W];
    c.en    = word[ch*CH_STRIDE + THR_W + SHIFT_W];
    return c;
  endfunction

endpackage

// File: rtl/stall_prescaler.sv
module stall_prescaler #(
  parameter int PS_W    = 13,
  parameter int SHIFT_W = 3,
  parameter int BASE    = 8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick_o
);

  localparam logic [PS_W-1:0] BASE_V = PS_W'(BASE);

  logic [PS_W-1:0] cnt;
  logic [PS_W-1:0] limit;
  logic            at_wrap;

  assign limit   = BASE_V >> shift;
  assign at_wrap = (cnt >= limit);
  assign tick_o  = run && at_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (at_wrap) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R1: a count at or past the limit returns to zero on the next edge
  p_wrap_return_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_wrap) |=> (cnt == '0));

  // R1: below the limit the count steps by one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_wrap) |=> (cnt == $past(cnt) + 1'b1));

  // R5: leaving the active state zeroes the count
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/stall_tick_timer.sv
module stall_tick_timer #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [THR_W-1:0] thr,
  input  logic             clr,
  output logic             irq_o
);

  localparam int          CNT_W   = THR_W + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] ticks;
  logic             over;

  assign over = run && (ticks > {1'b0, thr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ticks <= '0;
    else if (!run)                      ticks <= '0;
    else if (tick && ticks != CNT_TOP)  ticks <= ticks + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    irq_o <= 1'b0;
    else if (clr)  irq_o <= 1'b0;
    else if (over) irq_o <= 1'b1;
  end

  // R2: each tick advances the count until saturation
  p_tick_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && ticks != CNT_TOP) |=> (ticks == $past(ticks) + 1'b1));

  // R6: clear beats a concurrent set
  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq_o);

  // R6: the flag holds without a clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr) |=> irq_o);

  // R3: an inactive channel never raises its flag
  p_no_set_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !irq_o) |=> !irq_o);

endmodule

// File: rtl/stall_channel.sv
module stall_channel
  import stall_wd_pkg::*;
#(
  parameter int P_PS_W    = PS_W,
  parameter int P_SHIFT_W = SHIFT_W,
  parameter int P_THR_W   = THR_W,
  parameter int P_BASE    = PS_BASE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [P_SHIFT_W-1:0] shift,
  input  logic [P_THR_W-1:0]   thr,
  input  logic                 stall_i,
  input  logic                 xfer_i,
  input  logic                 clr_i,
  output logic                 irq_o
);

  logic run;
  logic tick;

  assign run = en && stall_i && !xfer_i;

  stall_prescaler #(
    .PS_W   (P_PS_W),
    .SHIFT_W(P_SHIFT_W),
    .BASE   (P_BASE)
  ) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .shift (shift),
    .tick_o(tick)
  );

  stall_tick_timer #(
    .THR_W(P_THR_W)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick),
    .thr  (thr),
    .clr  (clr_i),
    .irq_o(irq_o)
  );

  // R3: with enable low the flag can only stay or fall
  p_en_low_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !irq_o) |=> !irq_o);

endmodule

// File: rtl/dma_stall_watchdog.sv
module dma_stall_watchdog
  import stall_wd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_word,
  input  logic        tx_stall,
  input  logic        tx_xfer,
  input  logic        tx_irq_clr,
  input  logic        rx_stall,
  input  logic        rx_xfer,
  input  logic        rx_irq_clr,
  output logic        tx_hung_irq,
  output logic        rx_hung_irq
);

  localparam int USED_W = N_CH * CH_STRIDE;

  logic [N_CH-1:0] stall_v;
  logic [N_CH-1:0] xfer_v;
  logic [N_CH-1:0] clr_v;
  logic [N_CH-1:0] irq_v;
  logic            unused_cfg_hi;

  assign stall_v = {rx_stall, tx_stall};
  assign xfer_v  = {rx_xfer, tx_xfer};
  assign clr_v   = {rx_irq_clr, tx_irq_clr};
  assign unused_cfg_hi = ^cfg_word[31:USED_W];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    chan_cfg_t cc;
    assign cc = pick_cfg(cfg_word, c);

    stall_channel u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cc.en),
      .shift  (cc.shift),
      .thr    (cc.thr),
      .stall_i(stall_v[c]),
      .xfer_i (xfer_v[c]),
      .clr_i  (clr_v[c]),
      .irq_o  (irq_v[c])
    );
  end

  assign tx_hung_irq = irq_v[0];
  assign rx_hung_irq = irq_v[1];

  // R9: a transmit clear leaves a set receive flag alone when rx is not cleared
  p_rx_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hung_irq && !rx_irq_clr) |=> rx_hung_irq);

endmodule

// File: tb/dma_stall_watchdog_bench.sv
module dma_stall_watchdog_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = 32'h0;
  logic [1:0]  stall = 2'b00;
  logic [1:0]  xfer = 2'b00;
  logic [1:0]  clr = 2'b00;
  logic        tx_irq, rx_irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dma_stall_watchdog u_dma_stall_watchdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_word   (cfg),
    .tx_stall   (stall[0]),
    .tx_xfer    (xfer[0]),
    .tx_irq_clr (clr[0]),
    .rx_stall   (stall[1]),
    .rx_xfer    (xfer[1]),
    .rx_irq_clr (clr[1]),
    .tx_hung_irq(tx_irq),
    .rx_hung_irq(rx_irq)
  );

  function automatic logic irq_of(int ch);
    return (ch == 0) ? tx_irq : rx_irq;
  endfunction

  task automatic chk(string req, int ch, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s ch%0d at %0t: irq=%0b expected %0b", req, ch, $time, act, exp);
    end
  endtask

  task automatic set_ch(int ch, int thr, int sh, logic en);
    cfg[ch*12 +: 8]     = 8'(thr);
    cfg[ch*12 + 8 +: 3] = 3'(sh);
    cfg[ch*12 + 11]     = en;
  endtask

  task automatic idle_ch(int ch);
    @(negedge clk);
    stall[ch] = 1'b0;
    clr[ch]   = 1'b1;
    @(negedge clk);
    clr[ch]   = 1'b0;
    chk("R6 clear", ch, irq_of(ch), 1'b0);
  endtask

  task automatic fire_test(int ch, int thr, int sh, string req);
    int lim = 8000 >> sh;
    int e   = (thr + 1) * (lim + 1) + 1;
    @(negedge clk);
    set_ch(ch, thr, sh, 1'b1);
    stall[ch] = 1'b1;
    repeat (e - 1) @(posedge clk);
    #1 chk(req, ch, irq_of(ch), 1'b0);
    @(posedge clk);
    #1 chk(req, ch, irq_of(ch), 1'b1);
    idle_ch(ch);
    @(negedge clk);
    set_ch(ch, 0, 0, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 chk("R6 reset", 0, tx_irq, 1'b0);
    chk("R6 reset", 1, rx_irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cfg   = 32'hFF00_0000;  // R4: upper bits set, both channels disabled
    repeat (2) @(posedge clk);
    #1 chk("R6 reset", 0, tx_irq, 1'b0);
    chk("R6 reset", 1, rx_irq, 1'b0);
  endtask

  task automatic t_wrap_all();
    for (int sh = 0; sh < 8; sh++) fire_test(0, 0, sh, "R1 R7 tx wrap");
    fire_test(1, 0, 7, "R1 R7 rx wrap");
    fire_test(1, 0, 4, "R1 R7 rx wrap");
  endtask

  task automatic t_threshold();
    fire_test(0, 5, 7, "R2 threshold");
    fire_test(1, 2, 7, "R2 threshold");
    fire_test(1, 3, 6, "R4 rx fields");
    fire_test(0, 2, 5, "R4 tx fields");
  endtask

  task automatic t_enable();
    for (int ch = 0; ch < 2; ch++) begin
      @(negedge clk);
      set_ch(ch, 0, 7, 1'b0);
      stall[ch] = 1'b1;
      repeat (300) @(posedge clk);
      #1 chk("R3 disabled", ch, irq_of(ch), 1'b0);
      @(negedge clk);
      set_ch(ch, 0, 7, 1'b1);
      repeat (63) @(posedge clk);
      #1 chk("R3 restart", ch, irq_of(ch), 1'b0);
      @(posedge clk);
      #1 chk("R3 restart", ch, irq_of(ch), 1'b1);
      idle_ch(ch);
      @(negedge clk);
      set_ch(ch, 0, 0, 1'b0);
    end
  endtask

  task automatic t_xfer();
    @(negedge clk);
    set_ch(0, 1, 7, 1'b1);
    stall[0] = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    xfer[0] = 1'b1;
    @(negedge clk);
    xfer[0] = 1'b0;
    repeat (126) @(posedge clk);
    #1 chk("R5 xfer restart", 0, tx_irq, 1'b0);
    @(posedge clk);
    #1 chk("R5 xfer restart", 0, tx_irq, 1'b1);
    idle_ch(0);
    @(negedge clk);
    stall[0] = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    stall[0] = 1'b0;
    @(negedge clk);
    stall[0] = 1'b1;
    repeat (126) @(posedge clk);
    #1 chk("R5 stall drop", 0, tx_irq, 1'b0);
    @(posedge clk);
    #1 chk("R5 stall drop", 0, tx_irq, 1'b1);
    idle_ch(0);
  endtask

  task automatic t_clear();
    @(negedge clk);
    set_ch(1, 0, 7, 1'b1);
    stall[1] = 1'b1;
    repeat (64) @(posedge clk);
    #1 chk("R6 set", 1, rx_irq, 1'b1);
    repeat (50) @(posedge clk);
    #1 chk("R6 sticky", 1, rx_irq, 1'b1);
    @(negedge clk);
    clr[1] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1 chk("R6 clear wins", 1, rx_irq, 1'b0);
    end
    @(negedge clk);
    clr[1] = 1'b0;
    @(posedge clk);
    #1 chk("R6 re-set", 1, rx_irq, 1'b1);
    @(negedge clk);
    stall[1] = 1'b0;
    repeat (10) @(posedge clk);
    #1 chk("R6 sticky idle", 1, rx_irq, 1'b1);
    idle_ch(1);
    @(negedge clk);
    set_ch(1, 0, 0, 1'b0);
  endtask

  task automatic t_cfg_change();
    @(negedge clk);
    set_ch(0, 10, 7, 1'b1);
    stall[0] = 1'b1;
    repeat (194) @(posedge clk);
    #1 chk("R8 before change", 0, tx_irq, 1'b0);
    @(negedge clk);
    set_ch(0, 1, 7, 1'b1);
    @(posedge clk);
    #1 chk("R8 next edge", 0, tx_irq, 1'b1);
    idle_ch(0);
    @(negedge clk);
    set_ch(0, 0, 0, 1'b0);
  endtask

  task automatic t_independent();
    @(negedge clk);
    set_ch(0, 0, 7, 1'b1);
    set_ch(1, 0, 7, 1'b1);
    stall[1] = 1'b1;
    repeat (64) @(posedge clk);
    #1 chk("R9 rx fires", 1, rx_irq, 1'b1);
    chk("R9 tx quiet", 0, tx_irq, 1'b0);
    @(negedge clk);
    clr[0]  = 1'b1;
    xfer[0] = 1'b1;
    set_ch(0, 200, 0, 1'b0);
    @(negedge clk);
    clr[0]  = 1'b0;
    xfer[0] = 1'b0;
    chk("R9 rx kept", 1, rx_irq, 1'b1);
    idle_ch(1);
    @(negedge clk);
    set_ch(1, 0, 0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    cfg = 32'h0081_0810;
    t_reset();
    t_wrap_all();
    t_threshold();
    t_enable();
    t_xfer();
    t_clear();
    t_cfg_change();
    t_independent();
    finish_run();
  end

endmodule